// File: doc/BRIEF.md
# Self-Framing Serial Segment Latch

This block receives display data over a two-wire serial link: a serial clock and a serial data line, qualified by an active-low enable. A frame opens with a single logic-1 start bit and carries 35 data bits after it. Once the last data bit has been shifted in, the block copies the frame into a bank of static output latches by itself, with no separate load strobe. It then empties its shift register so that the next frame can follow straight away.

The latched bits drive 32 segment outputs, covering four seven-segment digits that each have a decimal point. Two of the latched bits drive auxiliary LED outputs. The outputs are plain static levels and are not multiplexed. The serial inputs are asynchronous to the block's system clock, so the block synchronises them and detects the edges of the serial clock by oversampling.

An internal power-on reset stretcher holds all state clear for a fixed number of system clocks after the power-good input rises. It is also re-triggered whenever that input is pulled low.

Top module: `segrx_top`

## Requirements
- R1: After `rstN` has been high for `PorCycles` system clocks, all `segOut` and `ledOut` bits are 0, and no earlier serial activity affects them.
- R2: A frame is one start bit of 1 followed by 35 data bits, which is 36 serial clock rising edges with `serEnN` low. The outputs take the new frame within 8 system clocks of the 36th rising edge.
- R3: Data bit n, counted from 1 as the first bit after the start bit, drives `segOut[n-1]` for n = 1..32. Digit k (1..4) uses `segOut[8(k-1)+7 : 8(k-1)]`, with segment a at offset 0 through g at offset 6 and the decimal point at offset 7.
- R4: Data bit 33 drives `ledOut[0]` and data bit 34 drives `ledOut[1]`. Data bit 35 is accepted but appears on no output.
- R5: While no frame is in progress, rising edges of the serial clock with data 0 are ignored and do not begin a frame.
- R6: Rising edges of the serial clock while `serEnN` is high are ignored and do not advance a frame in progress.
- R7: A frame cut short leaves the outputs unchanged, and the shift register is not cleared. Later rising edges continue the same frame, and the frame loads when its 35th data bit arrives.
- R8: After the falling edge that follows a frame's last bit, the shift register is empty, so a frame sent immediately afterwards loads correctly.
- R9: Outputs change only at a frame load. Activity on the data line without serial clock edges leaves them unchanged.
- R10: Pulling `rstN` low in the middle of a frame clears the outputs and discards the partial frame, so the next full frame loads correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial link |
| rstN | input | 1 | Active-low power-good input that starts the internal reset stretcher |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serData | input | 1 | Serial data line |
| serEnN | input | 1 | Active-low enable that qualifies serial clock edges |
| segOut | output | 32 | Static segment levels, eight per digit |
| ledOut | output | 2 | Static auxiliary LED levels |

## Verification
The bench aims at the framing edges of the block. It sends leading zeros before a start bit; a design that took any first edge as a start would shift every segment by one position. It inserts disabled clock pulses in the middle of a frame, which would misalign the bits if they were counted. It sends a short frame that is completed later, which a design that cleared or loaded early would garble. It also checks back-to-back frames, which fail if the clear is lost, a frame with only bit 35 set, which must light nothing, and a mid-frame reset, which must leave no stale count behind.

// File: rtl/segrx_pkg.sv
package segrx_pkg;
  // strobes from control to datapath, one system clock wide
  typedef struct packed {
    logic shift;  // take one data bit into the shift register
    logic load;   // copy the shift register into the output latch
    logic clear;  // empty the shift register
  } seg_strobe_t;
endpackage

// File: rtl/segrx_ctrl.sv
module segrx_ctrl
  import segrx_pkg::*;
#(
  parameter int FrameBits = 35,
  parameter int PorCycles = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serEnN,
  output logic        rst,
  output logic        dataBit,
  output seg_strobe_t strobe
);
  localparam int CntW = $clog2(FrameBits + 2);
  localparam int PorW = $clog2(PorCycles + 1);
  localparam logic [CntW-1:0] LastData  = CntW'(FrameBits);
  localparam logic [CntW-1:0] LoadState = CntW'(FrameBits + 1);
  localparam logic [PorW-1:0] PorDone   = PorW'(PorCycles);

  logic [PorW-1:0] porCnt;
  logic [2:0]      clkSync;
  logic [1:0]      datSync;
  logic [1:0]      enSync;
  logic [CntW-1:0] bitCnt;
  logic            loadQ;
  logic            rise, fall, enActive, shiftNow;

  // power-on reset stretcher
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) porCnt <= '0;
    else if (porCnt != PorDone) porCnt <= porCnt + 1'b1;
  end
  assign rst = (porCnt != PorDone);

  always_ff @(posedge clk) begin
    if (rst) begin
      clkSync <= '0;
      datSync <= '0;
      enSync  <= 2'b11;
    end else begin
      clkSync <= {clkSync[1:0], serClk};
      datSync <= {datSync[0], serData};
      enSync  <= {enSync[0], serEnN};
    end
  end

  assign rise     = clkSync[1] & ~clkSync[2];
  assign fall     = ~clkSync[1] & clkSync[2];
  assign enActive = ~enSync[1];
  assign dataBit  = datSync[1];
  assign shiftNow = rise && enActive && (bitCnt != '0) && (bitCnt <= LastData);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
      loadQ  <= 1'b0;
    end else begin
      loadQ <= shiftNow && (bitCnt == LastData);
      if (rise && enActive) begin
        if (bitCnt == '0) begin
          if (dataBit) bitCnt <= 1;
        end else if (bitCnt <= LastData) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (fall && bitCnt == LoadState) begin
        bitCnt <= '0;
      end
    end
  end

  assign strobe.shift = shiftNow;
  assign strobe.load  = loadQ;
  assign strobe.clear = fall && (bitCnt == LoadState);

  AST_IDLE_ZERO_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rise && enActive && bitCnt == '0 && !dataBit) |=> (bitCnt == '0)); // R5
  AST_DISABLED_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rise && !enActive) |=> $stable(bitCnt)); // R6
  AST_LOAD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> !strobe.load); // R2
  AST_LOAD_NEEDS_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
    strobe.load |-> (bitCnt == LoadState)); // R7
endmodule

// File: rtl/segrx_datapath.sv
module segrx_datapath
  import segrx_pkg::*;
#(
  parameter int FrameBits    = 35,
  parameter int NumDigits    = 4,
  parameter int SegsPerDigit = 8,
  parameter int NumLeds      = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            dataBit,
  input  seg_strobe_t                     strobe,
  output logic [NumDigits*SegsPerDigit-1:0] segOut,
  output logic [NumLeds-1:0]              ledOut
);
  localparam int SegBits = NumDigits * SegsPerDigit;
  localparam int OutBits = SegBits + NumLeds;

  logic [FrameBits-1:0] shiftReg;
  logic [OutBits-1:0]   latchQ;

  // first data bit ends in position 0 after a full frame
  always_ff @(posedge clk) begin
    if (rst || strobe.clear) shiftReg <= '0;
    else if (strobe.shift) shiftReg <= {dataBit, shiftReg[FrameBits-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) latchQ <= '0;
    else if (strobe.load) latchQ <= shiftReg[OutBits-1:0];
  end

  for (genvar d = 0; d < NumDigits; d++) begin : g_digit
    assign segOut[d*SegsPerDigit +: SegsPerDigit] = latchQ[d*SegsPerDigit +: SegsPerDigit];
  end
  for (genvar l = 0; l < NumLeds; l++) begin : g_led
    assign ledOut[l] = latchQ[SegBits + l];
  end

  AST_CLEAR_EMPTIES_SHIFT: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> (shiftReg == '0)); // R8
  AST_LOAD_COPIES_FRAME: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (latchQ == $past(shiftReg[OutBits-1:0]))); // R2
  AST_OUT_HOLDS_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> ($stable(segOut) && $stable(ledOut))); // R9
endmodule

// File: rtl/segrx_top.sv
module segrx_top
  import segrx_pkg::*;
#(
  parameter int FrameBits    = 35,
  parameter int NumDigits    = 4,
  parameter int SegsPerDigit = 8,
  parameter int NumLeds      = 2,
  parameter int PorCycles    = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              serClk,
  input  logic                              serData,
  input  logic                              serEnN,
  output logic [NumDigits*SegsPerDigit-1:0] segOut,
  output logic [NumLeds-1:0]                ledOut
);
  logic        rst;
  logic        dataBit;
  seg_strobe_t strobe;

  segrx_ctrl #(.FrameBits(FrameBits), .PorCycles(PorCycles)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serEnN(serEnN), .rst(rst), .dataBit(dataBit), .strobe(strobe)
  );

  segrx_datapath #(.FrameBits(FrameBits), .NumDigits(NumDigits),
                   .SegsPerDigit(SegsPerDigit), .NumLeds(NumLeds)) u_dp (
    .clk(clk), .rst(rst), .dataBit(dataBit), .strobe(strobe),
    .segOut(segOut), .ledOut(ledOut)
  );
endmodule

// File: tb/sim_segrx_top.sv
module sim_segrx_top;
  localparam int PorCycles = 16;
  localparam int NVec = 7;
  localparam logic [34:0] VECS [NVec] = '{
    35'h7_FFFF_FFFF, 35'h0_0000_0001, 35'h0_8000_0000, 35'h1_0000_0000,
    35'h2_0000_0000, 35'h4_0000_0000, 35'h5_A5C3_3C96
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serEnN = 1'b1;
  logic [31:0] segOut;
  logic [1:0]  ledOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  segrx_top #(.PorCycles(PorCycles)) u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serEnN(serEnN), .segOut(segOut), .ledOut(ledOut)
  );

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic d);
    serData = d;
    waitClk(4);
    serClk = 1'b1;
    waitClk(8);
    serClk = 1'b0;
    waitClk(4);
  endtask

  task automatic sendBits(logic [34:0] v, int first, int last);
    for (int i = first; i <= last; i++) pulse(v[i]);
  endtask

  task automatic sendFrame(logic [34:0] v);
    pulse(1'b1);
    sendBits(v, 0, 34);
  endtask

  task automatic expectOut(string req, logic [33:0] exp);
    waitClk(10);
    checks++;
    if ({ledOut, segOut} !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, {ledOut, segOut}, exp);
    end
  endtask

  initial begin
    logic [34:0] v, w;
    waitClk(3);
    rstN = 1'b1;
    waitClk(PorCycles + 4);
    expectOut("R1 reset state", 34'h0);
    serEnN = 1'b0;

    // R2 R3 R4: table of frames
    for (int k = 0; k < NVec; k++) begin
      sendFrame(VECS[k]);
      expectOut("R2/R3/R4 table frame", VECS[k][33:0]);
    end

    // R9: data line activity without clocks
    for (int i = 0; i < 6; i++) begin serData = i[0]; waitClk(3); end
    expectOut("R9 hold without clock", VECS[NVec-1][33:0]);

    // R5: leading zeros while idle
    v = 35'h3_1234_5678;
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    sendFrame(v);
    expectOut("R5 leading zeros", v[33:0]);

    // R6: disabled clock pulses mid-frame
    w = 35'h0_F0F0_0F0F;
    pulse(1'b1);
    sendBits(w, 0, 9);
    serEnN = 1'b1;
    pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1); pulse(1'b0);
    expectOut("R6 no change while disabled", v[33:0]);
    serEnN = 1'b0;
    sendBits(w, 10, 34);
    expectOut("R6 frame across disabled pulses", w[33:0]);

    // R7: short frame, then completion
    v = 35'h6_0C0C_A0A1;
    pulse(1'b1);
    sendBits(v, 0, 18);
    expectOut("R7 short frame no update", w[33:0]);
    sendBits(v, 19, 34);
    expectOut("R7 completed frame", v[33:0]);

    // R8: back-to-back frames
    w = 35'h1_8421_1248;
    sendFrame(35'h7_7777_7777);
    sendFrame(w);
    expectOut("R8 back to back", w[33:0]);

    // R3 R4: pseudo-random frames
    for (int k = 0; k < 4; k++) begin
      v = {$urandom, $urandom} & 35'h7_FFFF_FFFF;
      sendFrame(v);
      expectOut("R3/R4 random frame", v[33:0]);
    end

    // R10: reset mid-frame
    pulse(1'b1);
    sendBits(35'h7_FFFF_FFFF, 0, 15);
    rstN = 1'b0;
    waitClk(2);
    rstN = 1'b1;
    waitClk(PorCycles + 4);
    expectOut("R10 reset clears outputs", 34'h0);
    v = 35'h2_5555_AAAA;
    sendFrame(v);
    expectOut("R10 frame after reset", v[33:0]);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule